// File: doc/BRIEF.md
# Push-Pull Gate Sequencer with Soft Start and Fault Retry

This block turns a free-running oscillator into two alternating gate commands for a push-pull transformer stage. The oscillator is outside the block. It presents each period as a charge interval followed by a discharge interval, and the block sees this through a single phase flag. A steering latch hands each charge interval to one output in turn, so each output switches at half the oscillator rate. Both outputs are blanked for the whole discharge interval. A sync output marks the discharge interval, but only while the driver is switching.

Around this core the block sequences power-up and fault recovery:

- **Lockout.** While the supply-ok flag is low, everything stays silent.
- **Start delay.** After the flag rises, the block waits a fixed number of oscillator periods.
- **Soft start.** A short ramp follows, in which each pulse's leading edge is pushed later by a whole number of fast-clock slots. The delay shrinks by one slot per period until a full-width pulse appears.
- **Over-current.** An over-current event while switching blanks the outputs at once. The block then waits a retry count of periods and restarts through the same ramp.

All durations are counted in oscillator periods, so they scale with the oscillator frequency.

Top module: `pp_sequencer`

## Requirements
- R1: Charge intervals are assigned alternately to `drv_a_o` and `drv_b_o`. After every entry into soft start (first start, fault retry or supply recovery), the first pulse goes to `drv_a_o`.
- R2: Both drive outputs are low whenever `dis_i` is high, and the two are never high together. In the clock in which `dis_i` has just fallen, before the next rising edge, both outputs are still low.
- R3: `sync_o` is low whenever `dis_i` is low. While the block is in soft start or run, `sync_o` is high for every clock in which `dis_i` is high. In all other states it stays low.
- R4: While `uv_ok_i` is low, all three outputs are low in the same cycle and the sequencer returns to lockout. When the flag returns, the full start delay is repeated.
- R5: A period start is a rising clock edge at which `dis_i` is low after having been high at the previous edge. Counting from the release of lockout, the first START_CYC-1 period starts (58 by default) produce no output. The START_CYC-th period start (59th by default) begins soft start.
- R6: The charge interval is divided into SS_SLOTS slots (default 5) of SLOT_CLKS clocks each (default 4). In the k-th soft-start period (k = 0, 1, ...), the pulse rises SS_SLOTS-1-k slots after the period start. With the defaults, that is 16, 12, 8 and 4 clocks. The next period has zero delay and begins normal run.
- R7: `oc_i` high during soft start or run forces both outputs low in the same cycle and moves the sequencer into a retry wait. The first RETRY_CYC-1 period starts after the fault (59 by default) produce no output. The RETRY_CYC-th period start (60th by default) begins soft start again.
- R8: `oc_i` high during the start delay or the retry wait is ignored. The period at which soft start begins is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that samples the phase flag and times the slots |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_i | input | 1 | High during the oscillator discharge (dead-time) interval |
| uv_ok_i | input | 1 | Supply above the lockout threshold |
| oc_i | input | 1 | Over-current comparator output, high on fault |
| drv_a_o | output | 1 | Gate command for the first push-pull switch |
| drv_b_o | output | 1 | Gate command for the second push-pull switch |
| sync_o | output | 1 | Dead-time marker, high during discharge while switching |

## Verification
The assertions check the relations that must hold on every clock:

- blanking of both drives during discharge, and their mutual exclusion;
- sync silent during charge;
- the immediate silencing of all outputs by a low supply flag or by over-current;
- no drive in the cycle after an over-current event.

Only the bench's scenarios can show the sequence-level behaviour:

- the exact period count of the start delay and of the retry wait;
- the shrinking leading-edge delay, measured as per-period on-time;
- that the pulse order restarts on the first output;
- that an over-current event during a wait leaves the timing untouched.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

    typedef enum logic [2:0] {
        ST_LOCKOUT    = 3'd0,
        ST_START_WAIT = 3'd1,
        ST_SOFT       = 3'd2,
        ST_RUN        = 3'd3,
        ST_RETRY_WAIT = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sel_b;   // 0: next charge interval drives A, 1: drives B
    } seq_reg_t;

endpackage

// File: rtl/pp_phase_track.sv
// Samples the discharge flag, detects period starts and counts slots
// within the charge interval.
module pp_phase_track #(
    parameter int SLOT_CLKS = 4,
    parameter int SS_SLOTS  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dis_i,
    output logic                  period_start_o,
    output logic                  charge_o,
    output logic [IW-1:0]         slot_o
);
    localparam int IW = (SS_SLOTS > 1) ? $clog2(SS_SLOTS) : 1;
    localparam int TW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [IW-1:0] LAST_SLOT = IW'(SS_SLOTS - 1);

    typedef struct packed {
        logic          dis;
        logic [TW-1:0] tick;
        logic [IW-1:0] idx;
    } trk_t;

    trk_t trk_q, trk_d;
    logic slot_adv;

    generate
        if (SLOT_CLKS == 1) begin : g_single
            assign slot_adv = 1'b1;
        end else begin : g_multi
            assign slot_adv = (trk_q.tick == TW'(SLOT_CLKS - 1));
        end
    endgenerate

    assign period_start_o = trk_q.dis & ~dis_i;

    always_comb begin
        trk_d     = trk_q;
        trk_d.dis = dis_i;
        if (period_start_o) begin
            trk_d.tick = '0;
            trk_d.idx  = '0;
        end else if (!trk_q.dis) begin
            if (slot_adv) begin
                trk_d.tick = '0;
                if (trk_q.idx != LAST_SLOT) begin
                    trk_d.idx = trk_q.idx + 1'b1;
                end
            end else begin
                trk_d.tick = trk_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{dis: 1'b1, tick: '0, idx: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign charge_o = ~trk_q.dis;
    assign slot_o   = trk_q.idx;
endmodule

// File: rtl/pp_cycle_timer.sv
// Saturating count of oscillator periods, cleared on request.
module pp_cycle_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != {CW{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/pp_lead_ramp.sv
// Holds the leading-edge delay in slots; loads the longest delay and
// shortens it by one slot per step until it reaches zero.
module pp_lead_ramp #(
    parameter int SS_SLOTS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    output logic [IW-1:0] lead_o
);
    localparam int IW = (SS_SLOTS > 1) ? $clog2(SS_SLOTS) : 1;
    localparam logic [IW-1:0] MAX_LEAD = IW'(SS_SLOTS - 1);

    logic [IW-1:0] lead_q, lead_d;

    always_comb begin
        lead_d = lead_q;
        if (load_i) begin
            lead_d = MAX_LEAD;
        end else if (step_i && (lead_q != '0)) begin
            lead_d = lead_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q <= MAX_LEAD;
        end else begin
            lead_q <= lead_d;
        end
    end

    assign lead_o = lead_q;
endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
    import pp_seq_pkg::*;
#(
    parameter int START_CYC = 59,
    parameter int RETRY_CYC = 60,
    parameter int SS_SLOTS  = 5,
    parameter int SLOT_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dis_i,
    input  logic uv_ok_i,
    input  logic oc_i,
    output logic drv_a_o,
    output logic drv_b_o,
    output logic sync_o
);
    localparam int IW   = (SS_SLOTS > 1) ? $clog2(SS_SLOTS) : 1;
    localparam int MAXC = (START_CYC > RETRY_CYC) ? START_CYC : RETRY_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] START_LAST = CW'(START_CYC - 1);
    localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);

    seq_reg_t      seq_q, seq_d;
    logic          period_start;
    logic          charge;
    logic [IW-1:0] slot_idx;
    logic [IW-1:0] lead;
    logic [CW-1:0] wait_cnt;
    logic          ramp_load;
    logic          ramp_step;
    logic          timer_clear;
    logic          live;
    logic          pulse;

    pp_phase_track #(
        .SLOT_CLKS (SLOT_CLKS),
        .SS_SLOTS  (SS_SLOTS)
    ) u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .dis_i          (dis_i),
        .period_start_o (period_start),
        .charge_o       (charge),
        .slot_o         (slot_idx)
    );

    pp_cycle_timer #(
        .CW (CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (timer_clear),
        .tick_i  (period_start),
        .count_o (wait_cnt)
    );

    pp_lead_ramp #(
        .SS_SLOTS (SS_SLOTS)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ramp_load),
        .step_i (ramp_step),
        .lead_o (lead)
    );

    always_comb begin
        seq_d     = seq_q;
        ramp_load = 1'b0;
        if (!uv_ok_i) begin
            seq_d.state = ST_LOCKOUT;
        end else begin
            unique case (seq_q.state)
                ST_LOCKOUT: begin
                    seq_d.state = ST_START_WAIT;
                end
                ST_START_WAIT: begin
                    if (period_start && (wait_cnt == START_LAST)) begin
                        seq_d.state = ST_SOFT;
                        seq_d.sel_b = 1'b0;
                        ramp_load   = 1'b1;
                    end
                end
                ST_SOFT: begin
                    if (oc_i) begin
                        seq_d.state = ST_RETRY_WAIT;
                    end else if (period_start) begin
                        seq_d.sel_b = ~seq_q.sel_b;
                        if (lead == IW'(1)) begin
                            seq_d.state = ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (oc_i) begin
                        seq_d.state = ST_RETRY_WAIT;
                    end else if (period_start) begin
                        seq_d.sel_b = ~seq_q.sel_b;
                    end
                end
                ST_RETRY_WAIT: begin
                    if (period_start && (wait_cnt == RETRY_LAST)) begin
                        seq_d.state = ST_SOFT;
                        seq_d.sel_b = 1'b0;
                        ramp_load   = 1'b1;
                    end
                end
                default: begin
                    seq_d.state = ST_LOCKOUT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_LOCKOUT, sel_b: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign timer_clear = (seq_d.state != seq_q.state);
    assign ramp_step   = period_start && (seq_q.state == ST_SOFT);

    assign live    = ((seq_q.state == ST_SOFT) || (seq_q.state == ST_RUN))
                     && uv_ok_i && !oc_i;
    assign pulse   = live && charge && !dis_i && (slot_idx >= lead);
    assign drv_a_o = pulse && !seq_q.sel_b;
    assign drv_b_o = pulse &&  seq_q.sel_b;
    assign sync_o  = live && dis_i;
endmodule

// File: rtl/pp_sequencer_chk.sv
module pp_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic dis_i,
    input logic uv_ok_i,
    input logic oc_i,
    input logic drv_a_o,
    input logic drv_b_o,
    input logic sync_o
);
    // R2: blanking during discharge
    p_dead_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |-> (!drv_a_o && !drv_b_o));

    // R2: never both
    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_a_o, drv_b_o}));

    // R3: sync silent during charge
    p_sync_charge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_i |-> !sync_o);

    // R4: supply lockout silences everything
    p_uv_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_ok_i |-> (!drv_a_o && !drv_b_o && !sync_o));

    // R4: no drive in the cycle after lockout was seen
    p_uv_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_ok_i |=> (!drv_a_o && !drv_b_o));

    // R7: over-current silences the drives at once
    p_oc_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oc_i |-> (!drv_a_o && !drv_b_o && !sync_o));

    // R7: and in the following cycle as well
    p_oc_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oc_i |=> (!drv_a_o && !drv_b_o));
endmodule

bind pp_sequencer pp_sequencer_chk u_chk (.*);

// File: tb/sim_pp_sequencer.sv
module sim_pp_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CH = 24;
    localparam int DS = 4;

    // {A on-clocks, B on-clocks, sync clocks} per period, from the 58th
    // period start after lockout release onwards
    localparam logic [23:0] EXPV [0:7] = '{
        {8'd0,  8'd0,  8'd0},
        {8'd8,  8'd0,  8'd4},
        {8'd0,  8'd12, 8'd4},
        {8'd16, 8'd0,  8'd4},
        {8'd0,  8'd20, 8'd4},
        {8'd24, 8'd0,  8'd4},
        {8'd0,  8'd24, 8'd4},
        {8'd24, 8'd0,  8'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dis_i = 1'b1;
    logic uv_ok_i = 1'b0;
    logic oc_i = 1'b0;
    logic drv_a_o, drv_b_o, sync_o;

    int checks = 0;
    int errors = 0;
    int bad_dead = 0;
    int bad_sync = 0;
    int a_n, b_n, s_n;
    int za, zb, zs;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pp_sequencer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .dis_i   (dis_i),
        .uv_ok_i (uv_ok_i),
        .oc_i    (oc_i),
        .drv_a_o (drv_a_o),
        .drv_b_o (drv_b_o),
        .sync_o  (sync_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One oscillator period: CH charge clocks then DS discharge clocks.
    task automatic run_period(input int oc_at, input int uv_at,
                              output int an, output int bn, output int sn);
        an = 0; bn = 0; sn = 0;
        @(negedge clk);
        dis_i = 1'b0;
        #1;
        if (drv_a_o || drv_b_o) bad_dead++;
        for (int i = 0; i < CH; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == oc_at) oc_i = 1'b1;
            if (i == uv_at) uv_ok_i = 1'b0;
            #1;
            if (drv_a_o) an++;
            if (drv_b_o) bn++;
            if (drv_a_o && drv_b_o) bad_dead++;
            if (sync_o) bad_sync++;
        end
        oc_i  = 1'b0;
        dis_i = 1'b1;
        for (int i = 0; i < DS; i++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            if (drv_a_o || drv_b_o) bad_dead++;
            if (sync_o) sn++;
        end
    endtask

    // n silent periods; the oc_period-th one carries an over-current pulse
    task automatic run_silent(input int n, input int oc_period,
                              output int ta, output int tb, output int ts);
        int an, bn, sn;
        ta = 0; tb = 0; ts = 0;
        for (int p = 0; p < n; p++) begin
            run_period((p == oc_period) ? 0 : -1, -1, an, bn, sn);
            ta += an; tb += bn; ts += sn;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
    end

    initial begin
        // Reset state
        repeat (4) @(negedge clk);
        #1;
        check(!drv_a_o && !drv_b_o && !sync_o, "R4 reset outputs low",
              {drv_a_o, drv_b_o, sync_o}, 0);
        rst_n = 1'b1;

        // R4: a full period under lockout stays silent
        run_period(-1, -1, a_n, b_n, s_n);
        check(a_n + b_n + s_n == 0, "R4 lockout period silent", a_n + b_n + s_n, 0);

        // R5 / R8: release, 57 silent periods with an over-current pulse in one
        @(negedge clk);
        uv_ok_i = 1'b1;
        run_silent(57, 10, za, zb, zs);
        check(za + zb + zs == 0, "R5 R8 start delay silent", za + zb + zs, 0);

        // R1 R3 R5 R6: vector table, periods 58..65
        for (int v = 0; v < 8; v++) begin
            run_period(-1, -1, a_n, b_n, s_n);
            check((a_n == int'(EXPV[v][23:16])) && (b_n == int'(EXPV[v][15:8]))
                  && (s_n == int'(EXPV[v][7:0])),
                  $sformatf("R1 R3 R5 R6 vector %0d a/b/s=%0d/%0d/%0d", v, a_n, b_n, s_n),
                  a_n * 10000 + b_n * 100 + s_n,
                  int'(EXPV[v][23:16]) * 10000 + int'(EXPV[v][15:8]) * 100 + int'(EXPV[v][7:0]));
        end

        // R7: over-current during a B pulse at charge clock 10
        run_period(10, -1, a_n, b_n, s_n);
        check((a_n == 0) && (b_n == 10) && (s_n == 0), "R7 fault cuts B pulse",
              a_n * 10000 + b_n * 100 + s_n, 1000);

        // R7 / R8: 59 silent retry periods with an ignored over-current pulse
        run_silent(59, 20, za, zb, zs);
        check(za + zb + zs == 0, "R7 R8 retry wait silent", za + zb + zs, 0);

        // R1 R7: restart with soft start on A
        run_period(-1, -1, a_n, b_n, s_n);
        check((a_n == 8) && (b_n == 0) && (s_n == 4), "R1 R7 restart on A",
              a_n * 10000 + b_n * 100 + s_n, 80004);
        run_period(-1, -1, a_n, b_n, s_n);
        check((a_n == 0) && (b_n == 12), "R6 restart ramp step B", b_n, 12);
        run_period(-1, -1, a_n, b_n, s_n);
        check(a_n == 16, "R6 restart ramp step A", a_n, 16);
        run_period(-1, -1, a_n, b_n, s_n);
        check(b_n == 20, "R6 restart ramp step B last", b_n, 20);
        run_period(-1, -1, a_n, b_n, s_n);
        check(a_n == 24, "R6 restart full width", a_n, 24);

        // R4: supply drop during a full B pulse at charge clock 12
        run_period(-1, 12, a_n, b_n, s_n);
        check((b_n == 12) && (a_n == 0) && (s_n == 0), "R4 supply drop cuts pulse",
              a_n * 10000 + b_n * 100 + s_n, 1200);

        // R4 R5: recovery repeats the full start delay
        @(negedge clk);
        uv_ok_i = 1'b1;
        run_silent(58, -1, za, zb, zs);
        check(za + zb + zs == 0, "R4 R5 delay repeated", za + zb + zs, 0);
        run_period(-1, -1, a_n, b_n, s_n);
        check((a_n == 8) && (b_n == 0) && (s_n == 4), "R1 R4 recovery on A",
              a_n * 10000 + b_n * 100 + s_n, 80004);

        check(bad_dead == 0, "R2 dead-time blanking", bad_dead, 0);
        check(bad_sync == 0, "R3 sync in charge", bad_sync, 0);
        summary();
    end
endmodule